// File: doc/BRIEF.md
# Programmable CRC32 Register-Mapped Engine

This block computes a 32-bit cyclic redundancy checksum over a stream of 32-bit words that software writes through a small register window. Software first programs a seed value and a generator polynomial, then issues a restart command that copies the seed into the running checksum. Every write to the data register folds one full word into the checksum. A read of that same register returns the current checksum.

The engine works internally in normal, MSB-first form. Optional reversal of each input word and of the checksum on read lets it give the reflected, little-endian results of the common CRC-32 and CRC-32C codes without changing the datapath. With generator 0x04C11DB7, seed 0xFFFFFFFF and both reversals enabled, the data register reads back the reflected CRC-32 remainder before any final inversion. With generator 0x1EDC6F41 it reads back the CRC-32C remainder, which the caller inverts to get the standard value.

Top module: `crc_mmio_engine`

## Requirements
- R1: After reset, the checksum reads 0xFFFFFFFF, the seed register reads 0xFFFFFFFF, the polynomial register reads 0x04C11DB7 and the control register reads 0.
- R2: The seed register (offset 0x10) and the polynomial register (offset 0x14) read back the last value written to them.
- R3: Writing 1 to control bit 0 (offset 0x08) copies the seed register into the checksum, visible on a data read in the next cycle. Bit 0 always reads 0.
- R4: With control 0, a write of word w to the data register (offset 0x00) replaces checksum c with the MSB-first division remainder: c is XORed with w, then shifted left 32 times, and the polynomial is XORed in whenever the bit shifted out is 1. The result is visible on a read in the next cycle.
- R5: When control bits 6:5 equal 2'b11, each data word is bit-reversed (bit i goes to bit 31-i) before it is folded in. Any other value of bits 6:5 folds the word unchanged.
- R6: When control bit 7 is 1, a read of the data register returns the bit-reversed checksum. Control bits 7:5 read back as written.
- R7: With polynomial 0x04C11DB7, seed 0xFFFFFFFF and control 0xE0, the data register reads the reflected CRC-32 remainder of the little-endian byte stream, with no final XOR. Four zero bytes give 0xDEBB20E3 and four 0xFF bytes give 0x00000000.
- R8: With polynomial 0x1EDC6F41, seed 0xFFFFFFFF and control 0xE0, the data register reads the reflected CRC-32C remainder, with no final XOR. Four zero bytes give 0xB798B438.
- R9: Reads of unmapped offsets return 0. Writes to unmapped offsets change neither the configuration nor the checksum.
- R10: Reads have no side effects: the checksum stays the same until the next data write or restart command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, 0 when bus_rd is low |

## Verification
The bench builds the engine with its default 8-bit address, so it can reach unmapped offsets between and beyond the four registers, such as 0x04, 0x0C and 0xFC. The 32-bit checksum width is fixed, so the bench runs every control mode (no reversal, input reversal only, output reversal only, full reversal, and the 2'b01/2'b10 input encodings) with both standard polynomials and with random polynomials and seeds. It compares against a reflected bitwise model, which it maps to normal form through bit reversal. Directed all-zero and all-ones words pin known CRC-32 and CRC-32C remainders.

// File: rtl/crc_mmio_pkg.sv
package crc_mmio_pkg;

  localparam int unsigned CRC_W = 32;

  localparam logic [7:0] OFS_DATA = 8'h00;
  localparam logic [7:0] OFS_CTRL = 8'h08;
  localparam logic [7:0] OFS_SEED = 8'h10;
  localparam logic [7:0] OFS_POLY = 8'h14;

  localparam logic [CRC_W-1:0] SEED_RST = 32'hFFFF_FFFF;
  localparam logic [CRC_W-1:0] POLY_RST = 32'h04C1_1DB7;

  localparam int unsigned CMD_BIT    = 0;
  localparam int unsigned INMODE_LO  = 5;
  localparam int unsigned INMODE_HI  = 6;
  localparam int unsigned OUTREV_BIT = 7;

  typedef enum logic [1:0] {
    IN_PLAIN   = 2'b00,
    IN_REV_WRD = 2'b11
  } in_mode_e;

  typedef struct packed {
    logic       out_rev;
    logic [1:0] in_mode;
  } ctrl_t;

  function automatic logic [CRC_W-1:0] bitrev_w(input logic [CRC_W-1:0] v);
    logic [CRC_W-1:0] r;
    for (int i = 0; i < CRC_W; i++) r[i] = v[CRC_W-1-i];
    return r;
  endfunction

  function automatic logic [CRC_W-1:0] shift_step(input logic [CRC_W-1:0] s,
                                                  input logic [CRC_W-1:0] poly);
    return s[CRC_W-1] ? ({s[CRC_W-2:0], 1'b0} ^ poly) : {s[CRC_W-2:0], 1'b0};
  endfunction

endpackage

// File: rtl/crc_cfg_regs.sv
module crc_cfg_regs
  import crc_mmio_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_seed,
  input  logic             wr_poly,
  input  logic             wr_ctrl,
  input  logic [CRC_W-1:0] wdata,
  output logic [CRC_W-1:0] seed_q,
  output logic [CRC_W-1:0] poly_q,
  output logic             in_rev,
  output logic             out_rev,
  output logic [CRC_W-1:0] ctrl_rd,
  output logic             restart_cmd
);

  ctrl_t ctrl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seed_q <= SEED_RST;
      poly_q <= POLY_RST;
      ctrl_q <= '0;
    end else begin
      if (wr_seed) seed_q <= wdata;
      if (wr_poly) poly_q <= wdata;
      if (wr_ctrl) begin
        ctrl_q.out_rev <= wdata[OUTREV_BIT];
        ctrl_q.in_mode <= wdata[INMODE_HI:INMODE_LO];
      end
    end
  end

  assign restart_cmd = wr_ctrl & wdata[CMD_BIT];
  assign in_rev      = (ctrl_q.in_mode == IN_REV_WRD);
  assign out_rev     = ctrl_q.out_rev;

  always_comb begin
    ctrl_rd                       = '0;
    ctrl_rd[OUTREV_BIT]           = ctrl_q.out_rev;
    ctrl_rd[INMODE_HI:INMODE_LO]  = ctrl_q.in_mode;
  end

  assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_seed && !wr_poly) |=> ($stable(seed_q) && $stable(poly_q)));

  assert_ctrl_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ctrl |=> $stable(ctrl_rd));

endmodule

// File: rtl/crc_fold_unit.sv
module crc_fold_unit
  import crc_mmio_pkg::*;
(
  input  logic [CRC_W-1:0] crc_in,
  input  logic [CRC_W-1:0] word_in,
  input  logic [CRC_W-1:0] poly,
  input  logic             in_rev,
  output logic [CRC_W-1:0] crc_out
);

  logic [CRC_W-1:0] word_eff;
  logic [CRC_W-1:0] stage [CRC_W+1];

  assign word_eff = in_rev ? bitrev_w(word_in) : word_in;
  assign stage[0] = crc_in ^ word_eff;

  for (genvar g = 0; g < CRC_W; g++) begin : g_step
    assign stage[g+1] = shift_step(stage[g], poly);
  end

  assign crc_out = stage[CRC_W];

  always_comb begin
    if (poly == '0) begin
      assert_zero_poly_R4: assert (crc_out == '0);
    end
  end

endmodule

// File: rtl/crc_accum.sv
module crc_accum
  import crc_mmio_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CRC_W-1:0] seed,
  input  logic             fold_en,
  input  logic [CRC_W-1:0] fold_val,
  input  logic             out_rev,
  output logic [CRC_W-1:0] chk_q,
  output logic [CRC_W-1:0] chk_rd
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       chk_q <= SEED_RST;
    else if (load)    chk_q <= seed;
    else if (fold_en) chk_q <= fold_val;
  end

  assign chk_rd = out_rev ? bitrev_w(chk_q) : chk_q;

  assert_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (chk_q == $past(seed)));

  assert_fold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fold_en && !load) |=> (chk_q == $past(fold_val)));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!fold_en && !load) |=> $stable(chk_q));

endmodule

// File: rtl/crc_mmio_engine.sv
module crc_mmio_engine
  import crc_mmio_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CRC_W-1:0]  bus_wdata,
  output logic [CRC_W-1:0]  bus_rdata
);

  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFS_DATA);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_SEED = ADDR_W'(OFS_SEED);
  localparam logic [ADDR_W-1:0] A_POLY = ADDR_W'(OFS_POLY);

  logic hit_data, hit_ctrl, hit_seed, hit_poly, hit_none;
  logic wr_data, wr_ctrl, wr_seed, wr_poly;
  logic [CRC_W-1:0] seed_q, poly_q, ctrl_rd, chk_q, chk_rd, fold_val;
  logic in_rev, out_rev, restart_cmd;
  logic [CRC_W-1:0] rd_mux;

  assign hit_data = (bus_addr == A_DATA);
  assign hit_ctrl = (bus_addr == A_CTRL);
  assign hit_seed = (bus_addr == A_SEED);
  assign hit_poly = (bus_addr == A_POLY);
  assign hit_none = !(hit_data || hit_ctrl || hit_seed || hit_poly);

  assign wr_data = bus_wr & hit_data;
  assign wr_ctrl = bus_wr & hit_ctrl;
  assign wr_seed = bus_wr & hit_seed;
  assign wr_poly = bus_wr & hit_poly;

  crc_cfg_regs u_cfg (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_seed     (wr_seed),
    .wr_poly     (wr_poly),
    .wr_ctrl     (wr_ctrl),
    .wdata       (bus_wdata),
    .seed_q      (seed_q),
    .poly_q      (poly_q),
    .in_rev      (in_rev),
    .out_rev     (out_rev),
    .ctrl_rd     (ctrl_rd),
    .restart_cmd (restart_cmd)
  );

  crc_fold_unit u_fold (
    .crc_in  (chk_q),
    .word_in (bus_wdata),
    .poly    (poly_q),
    .in_rev  (in_rev),
    .crc_out (fold_val)
  );

  crc_accum u_acc (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (restart_cmd),
    .seed     (seed_q),
    .fold_en  (wr_data),
    .fold_val (fold_val),
    .out_rev  (out_rev),
    .chk_q    (chk_q),
    .chk_rd   (chk_rd)
  );

  always_comb begin
    rd_mux = '0;
    if (hit_data) rd_mux = chk_rd;
    if (hit_ctrl) rd_mux = ctrl_rd;
    if (hit_seed) rd_mux = seed_q;
    if (hit_poly) rd_mux = poly_q;
  end

  assign bus_rdata = bus_rd ? rd_mux : '0;

  assert_unmapped_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && hit_none) |=> ($stable(chk_q) && $stable(seed_q) && $stable(poly_q) && $stable(ctrl_rd)));

  assert_cmd_reads_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && hit_ctrl) |-> (bus_rdata[CMD_BIT] == 1'b0));

endmodule

// File: tb/tb_crc_mmio_engine.sv
module tb_crc_mmio_engine;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;

  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  crc_mmio_engine #(.ADDR_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  function automatic logic [31:0] rev32(input logic [31:0] v);
    logic [31:0] r = '0;
    for (int k = 0; k < 32; k++) if (v[k]) r[31-k] = 1'b1;
    return r;
  endfunction

  // Reflected, LSB-first CRC over one little-endian word.
  function automatic logic [31:0] refl_word(input logic [31:0] st,
                                            input logic [31:0] w,
                                            input logic [31:0] rpoly);
    logic [31:0] s = st ^ w;
    for (int k = 0; k < 32; k++) s = s[0] ? ((s >> 1) ^ rpoly) : (s >> 1);
    return s;
  endfunction

  // Normal-form update expressed through the reflected model.
  function automatic logic [31:0] norm_word(input logic [31:0] st,
                                            input logic [31:0] w,
                                            input logic [31:0] poly);
    return rev32(refl_word(rev32(st), rev32(w), rev32(poly)));
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s: got %08h expected %08h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic summary;
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      miscompares++;
      $display("FAIL watchdog: got %0d expected <150000 cycles", cycles);
      summary();
    end
  end

  // Runs a random stream in a given control mode, tracking normal-form state.
  task automatic run_mode(input string tag, input logic [31:0] ctrl,
                          input logic [31:0] poly, input logic [31:0] seed, input int nwords);
    logic [31:0] st, w, got;
    bit irev, orev;
    irev = (ctrl[6:5] == 2'b11);
    orev = ctrl[7];
    wr(8'h14, poly);
    wr(8'h10, seed);
    wr(8'h08, ctrl | 32'h1);
    st = seed;
    rd(8'h00, got);
    check({tag, " restart R3"}, got, orev ? rev32(st) : st);
    for (int n = 0; n < nwords; n++) begin
      w = $urandom;
      wr(8'h00, w);
      st = norm_word(st, irev ? rev32(w) : w, poly);
      rd(8'h00, got);
      check(tag, got, orev ? rev32(st) : st);
    end
  endtask

  initial begin
    logic [31:0] got, st;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset values
    rd(8'h00, got); check("R1 checksum", got, 32'hFFFF_FFFF);
    rd(8'h10, got); check("R1 seed", got, 32'hFFFF_FFFF);
    rd(8'h14, got); check("R1 poly", got, 32'h04C1_1DB7);
    rd(8'h08, got); check("R1 ctrl", got, 32'h0);

    // R2: readback
    wr(8'h10, 32'h1234_5678); rd(8'h10, got); check("R2 seed", got, 32'h1234_5678);
    wr(8'h14, 32'hA5A5_0F0F); rd(8'h14, got); check("R2 poly", got, 32'hA5A5_0F0F);

    // R3 / R6: control readback drops bit 0, keeps 7:5
    wr(8'h08, 32'hFFFF_FFFF); rd(8'h08, got); check("R3 R6 ctrl readback", got, 32'h0000_00E0);
    rd(8'h00, got); check("R3 restart loads seed (reversed out)", got, rev32(32'h1234_5678));

    // R10: repeated reads do not change checksum
    rd(8'h00, got); check("R10 read twice", got, rev32(32'h1234_5678));

    // R7 directed: CRC-32 of zero and of all-ones words
    wr(8'h14, 32'h04C1_1DB7); wr(8'h10, 32'hFFFF_FFFF); wr(8'h08, 32'hE1);
    wr(8'h00, 32'h0); rd(8'h00, got); check("R7 zero word", got, 32'hDEBB_20E3);
    wr(8'h08, 32'hE1);
    wr(8'h00, 32'hFFFF_FFFF); rd(8'h00, got); check("R7 ones word", got, 32'h0000_0000);

    // R8 directed: CRC-32C of a zero word
    wr(8'h14, 32'h1EDC_6F41); wr(8'h08, 32'hE1);
    wr(8'h00, 32'h0); rd(8'h00, got); check("R8 zero word", got, 32'hB798_B438);

    // R7 random stream vs direct reflected model
    wr(8'h14, 32'h04C1_1DB7); wr(8'h08, 32'hE1);
    st = 32'hFFFF_FFFF;
    for (int n = 0; n < 40; n++) begin
      logic [31:0] w;
      w = $urandom;
      wr(8'h00, w);
      st = refl_word(st, w, 32'hEDB8_8320);
      rd(8'h00, got); check("R7 stream", got, st);
    end

    // R8 random stream vs direct reflected model
    wr(8'h14, 32'h1EDC_6F41); wr(8'h08, 32'hE1);
    st = 32'hFFFF_FFFF;
    for (int n = 0; n < 40; n++) begin
      logic [31:0] w;
      w = (n % 8 == 3) ? 32'h0 : ((n % 8 == 5) ? 32'hFFFF_FFFF : $urandom);
      wr(8'h00, w);
      st = refl_word(st, w, 32'h82F6_3B78);
      rd(8'h00, got); check("R8 stream", got, st);
    end

    // R4, R5, R6: mode combinations
    run_mode("R4 plain", 32'h00, 32'h04C1_1DB7, 32'hFFFF_FFFF, 20);
    run_mode("R4 plain rnd poly", 32'h00, $urandom, $urandom, 20);
    run_mode("R5 in rev", 32'h60, 32'h1EDC_6F41, $urandom, 20);
    run_mode("R5 mode01 plain", 32'h20, $urandom, $urandom, 15);
    run_mode("R5 mode10 plain", 32'h40, $urandom, $urandom, 15);
    run_mode("R6 out rev", 32'h80, $urandom, $urandom, 15);
    run_mode("R7 full rev rnd", 32'hE0, $urandom, $urandom, 20);

    // R9: unmapped reads give zero, unmapped writes change nothing
    wr(8'h14, 32'h04C1_1DB7); wr(8'h10, 32'hCAFE_F00D); wr(8'h08, 32'h01);
    rd(8'h04, got); check("R9 read 0x04", got, 32'h0);
    rd(8'h0C, got); check("R9 read 0x0C", got, 32'h0);
    rd(8'hFC, got); check("R9 read 0xFC", got, 32'h0);
    wr(8'h04, 32'h1111_1111);
    wr(8'h0C, 32'hFFFF_FFFF);
    wr(8'h18, 32'h2222_2222);
    wr(8'h11, 32'h3333_3333);
    rd(8'h00, got); check("R9 checksum kept", got, 32'hCAFE_F00D);
    rd(8'h10, got); check("R9 seed kept", got, 32'hCAFE_F00D);
    rd(8'h14, got); check("R9 poly kept", got, 32'h04C1_1DB7);
    rd(8'h08, got); check("R9 ctrl kept", got, 32'h0);

    // R2: data and restart writes leave configuration untouched
    wr(8'h00, 32'hDEAD_BEEF);
    rd(8'h10, got); check("R2 seed after data", got, 32'hCAFE_F00D);

    // R10: bus_rd low gives zero and no side effect
    st = norm_word(32'hCAFE_F00D, 32'hDEAD_BEEF, 32'h04C1_1DB7);
    @(negedge clk); bus_addr = 8'h00; #1 check("R10 idle rdata", bus_rdata, 32'h0);
    rd(8'h00, got); check("R10 checksum after idle", got, st);

    summary();
  end

endmodule